// File: doc/BRIEF.md
# Multithreaded In-Order Issue Scheduler

This block is the issue stage of a core that runs many hardware threads in strict program order. No rename tables are used. Every thread owns a slice of the physical register file, and the physical index is built as `{thread, architectural register}`. The scheduler keeps one small in-order queue per thread. Each cycle it looks only at the head of every queue and decides whether that head's source operands are available. It then hands up to `ISSUE_W` ready heads to the execution lanes, picking threads in round-robin order.

Operand tracking uses one ready bit per physical register:
- Issuing an instruction that writes a register marks that register pending.
- A writeback result marks it available again.
- A writeback that arrives in the same cycle as a dependent head counts as available at once. This is the forwarding path that covers the delayed register-file write.

Dispatch uses valid/ready. `disp_ready` depends on the thread named by `disp_tid`, so a full queue stalls only its own thread. A transfer happens on a rising edge where both `disp_valid` and `disp_ready` are high. Issue uses valid/ready too, with one shared `iss_ready`. When it is low, nothing leaves and no state moves except dispatch and writeback.

`flush` empties every queue and marks every register available.

Top module: `mt_inorder_issue`

## Requirements
- R1: After reset no issue slot is valid, `disp_ready` is high for every thread, and every physical register is marked available. An instruction whose sources were never written issues as soon as it reaches its queue head.
- R2: The physical index on `wb_preg` is `{tid[2:0], areg[3:0]}`, with the thread in the upper 3 bits. A writeback wakes only sources of that thread that name that architectural register. The same register number of another thread is not affected.
- R3: A dispatch is accepted on a clock edge where `disp_valid` and `disp_ready` are both high, and it is appended to the tail of queue `disp_tid`. `disp_ready` is low exactly when `flush` is high or that thread's queue holds `FIFO_DEPTH` entries. Other threads stay ready.
- R4: Only the head of each queue may issue, so instructions of one thread issue in dispatch order, at most one per thread per cycle. An entry accepted at edge E can be seen on the issue ports no earlier than just after E.
- R5: A head is ready when each source it uses (`*_use`=1) is marked available, or is hit by a `wb_valid`/`wb_preg` pair in the same cycle. In the second case it issues in that same cycle.
- R6: Issuing an instruction with `dst_we`=1 marks `{tid,dst}` pending from the next edge on. A later writeback to that index marks it available. If both happen on the same edge, the pending mark wins.
- R7: Up to `ISSUE_W` ready heads issue per cycle. Granted threads fill slots 0,1,2,… with no gaps, in round-robin order starting at the pointer thread and wrapping from 7 to 0.
- R8: The round-robin pointer is 0 after reset. After a cycle with grants it moves to one past the last granted thread (modulo 8). After a cycle with no grants it holds.
- R9: While `iss_ready` is low no slot is valid and no queue entry is removed.
- R10: While `flush` is high no slot is valid and no dispatch is accepted. From the next edge every queue is empty and every register is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all queues, mark all registers available |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Queue of `disp_tid` can accept |
| disp_tid | input | 3 | Thread of the dispatched instruction |
| disp_src0 | input | 4 | First source architectural register |
| disp_src0_use | input | 1 | First source is read |
| disp_src1 | input | 4 | Second source architectural register |
| disp_src1_use | input | 1 | Second source is read |
| disp_dst | input | 4 | Destination architectural register |
| disp_dst_we | input | 1 | Instruction writes `disp_dst` |
| disp_pay | input | 16 | Opaque instruction payload |
| iss_ready | input | 1 | Execution lanes accept this cycle |
| iss_valid | output | ISSUE_W | Per-slot issue valid |
| iss_tid | output | ISSUE_W*3 | Per-slot thread, slot k at bits [3k+2:3k] |
| iss_dst | output | ISSUE_W*4 | Per-slot destination register |
| iss_dst_we | output | ISSUE_W | Per-slot destination write enable |
| iss_pay | output | ISSUE_W*16 | Per-slot payload |
| wb_valid | input | WB_PORTS | Per-port writeback valid |
| wb_preg | input | WB_PORTS*7 | Per-port physical register index |

## Verification
The bench builds the block with `ISSUE_W`=4, `WB_PORTS`=2 and `FIFO_DEPTH`=2. The shallow queue reaches the full condition after two dispatches, so per-thread back-pressure and program order within a thread can be seen in a few cycles. Loading six threads while `iss_ready` is low puts more ready heads up than there are slots. This shows the slot packing and the pointer wrapping from thread 7 back to lower threads. Writebacks are driven in the same cycle as a waiting head, both on the matching index and on the same register number of another thread, to exercise forwarding and index isolation.

// File: rtl/mtis_pkg.sv
`timescale 1ns/1ps
package mtis_pkg;
  localparam int TID_W       = 3;
  localparam int AREG_W      = 4;
  localparam int PAY_W       = 16;
  localparam int PREG_W      = TID_W + AREG_W;
  localparam int NUM_THREADS = 1 << TID_W;
  localparam int NUM_PREGS   = 1 << PREG_W;

  typedef struct packed {
    logic [AREG_W-1:0] src0;
    logic              use0;
    logic [AREG_W-1:0] src1;
    logic              use1;
    logic [AREG_W-1:0] dst;
    logic              dst_we;
    logic [PAY_W-1:0]  pay;
  } mtis_op_t;
endpackage

// File: rtl/mtis_thread_fifo.sv
`timescale 1ns/1ps
// In-order queue for one thread; DEPTH must be a power of two, at least 2.
module mtis_thread_fifo
  import mtis_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     push,
  input  mtis_op_t din,
  input  logic     pop,
  output mtis_op_t dout,
  output logic     empty,
  output logic     full
);
  localparam int PW = $clog2(DEPTH);

  mtis_op_t       mem [DEPTH];
  logic [PW-1:0]  rd_q, wr_q;
  logic [PW:0]    cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + PW'(1);
      if (pop)  rd_q <= rd_q + PW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + (PW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (PW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (PW+1)'(DEPTH));
endmodule

// File: rtl/mtis_scoreboard.sv
`timescale 1ns/1ps
// One availability bit per physical register, with same-cycle writeback forwarding.
module mtis_scoreboard #(
  parameter int PREG_W    = 7,
  parameter int WB_PORTS  = 2,
  parameter int CLR_PORTS = 8,
  parameter int NQ        = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [WB_PORTS-1:0]       wb_valid,
  input  logic [WB_PORTS*PREG_W-1:0] wb_preg,
  input  logic [CLR_PORTS-1:0]      clr_valid,
  input  logic [CLR_PORTS*PREG_W-1:0] clr_preg,
  input  logic [NQ*PREG_W-1:0]      q_preg,
  output logic [NQ-1:0]             q_ready
);
  localparam int NPREG = 1 << PREG_W;

  logic [NPREG-1:0] avail_q, avail_d;

  always_comb begin
    avail_d = avail_q;
    for (int w = 0; w < WB_PORTS; w++)
      if (wb_valid[w]) avail_d[wb_preg[w*PREG_W +: PREG_W]] = 1'b1;
    // pending marks from new issues override older results
    for (int c = 0; c < CLR_PORTS; c++)
      if (clr_valid[c]) avail_d[clr_preg[c*PREG_W +: PREG_W]] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     avail_q <= '1;
    else if (flush) avail_q <= '1;
    else            avail_q <= avail_d;
  end

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      q_ready[q] = avail_q[q_preg[q*PREG_W +: PREG_W]];
      for (int w = 0; w < WB_PORTS; w++)
        if (wb_valid[w] && (wb_preg[w*PREG_W +: PREG_W] == q_preg[q*PREG_W +: PREG_W]))
          q_ready[q] = 1'b1;
    end
  end
endmodule

// File: rtl/mtis_rr_select.sv
`timescale 1ns/1ps
// Round-robin grant of up to ISSUE_W requesters, packed into slots in grant order.
module mtis_rr_select #(
  parameter int TID_W   = 3,
  parameter int ISSUE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [(1<<TID_W)-1:0]    req,
  output logic [(1<<TID_W)-1:0]    grant,
  output logic [ISSUE_W-1:0]       slot_vld,
  output logic [ISSUE_W*TID_W-1:0] slot_tid
);
  localparam int N = 1 << TID_W;

  logic [TID_W-1:0] ptr_q, ptr_d, t, last;
  int               cnt;

  always_comb begin
    grant    = '0;
    slot_vld = '0;
    slot_tid = '0;
    last     = ptr_q;
    cnt      = 0;
    t        = '0;
    for (int i = 0; i < N; i++) begin
      t = ptr_q + TID_W'(i);
      if (req[t] && (cnt < ISSUE_W)) begin
        grant[t]                        = 1'b1;
        slot_vld[cnt]                   = 1'b1;
        slot_tid[cnt*TID_W +: TID_W]    = t;
        last                            = t;
        cnt                             = cnt + 1;
      end
    end
    ptr_d = (grant != '0) ? last + TID_W'(1) : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/mt_inorder_issue.sv
`timescale 1ns/1ps
module mt_inorder_issue
  import mtis_pkg::*;
#(
  parameter int ISSUE_W    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int WB_PORTS   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       disp_valid,
  output logic                       disp_ready,
  input  logic [TID_W-1:0]           disp_tid,
  input  logic [AREG_W-1:0]          disp_src0,
  input  logic                       disp_src0_use,
  input  logic [AREG_W-1:0]          disp_src1,
  input  logic                       disp_src1_use,
  input  logic [AREG_W-1:0]          disp_dst,
  input  logic                       disp_dst_we,
  input  logic [PAY_W-1:0]           disp_pay,
  input  logic                       iss_ready,
  output logic [ISSUE_W-1:0]         iss_valid,
  output logic [ISSUE_W*TID_W-1:0]   iss_tid,
  output logic [ISSUE_W*AREG_W-1:0]  iss_dst,
  output logic [ISSUE_W-1:0]         iss_dst_we,
  output logic [ISSUE_W*PAY_W-1:0]   iss_pay,
  input  logic [WB_PORTS-1:0]        wb_valid,
  input  logic [WB_PORTS*PREG_W-1:0] wb_preg
);
  localparam int N  = NUM_THREADS;
  localparam int NQ = 2 * N;

  mtis_op_t                 disp_op;
  mtis_op_t                 head_q [N];
  logic [N-1:0]             q_empty, q_full, q_push, head_rdy, req, grant;
  logic [N-1:0]             clr_valid;
  logic [N*PREG_W-1:0]      clr_preg;
  logic [NQ*PREG_W-1:0]     q_preg;
  logic [NQ-1:0]            q_ready;
  logic [ISSUE_W-1:0]       slot_vld;
  logic [ISSUE_W*TID_W-1:0] slot_tid;
  logic                     disp_fire;

  assign disp_op    = '{src0: disp_src0, use0: disp_src0_use, src1: disp_src1,
                        use1: disp_src1_use, dst: disp_dst, dst_we: disp_dst_we,
                        pay: disp_pay};
  assign disp_ready = !flush && !q_full[disp_tid];
  assign disp_fire  = disp_valid && disp_ready;

  for (genvar g = 0; g < N; g++) begin : g_thr
    localparam logic [TID_W-1:0] TID = TID_W'(g);

    assign q_push[g] = disp_fire && (disp_tid == TID);

    mtis_thread_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (q_push[g]),
      .din   (disp_op),
      .pop   (grant[g]),
      .dout  (head_q[g]),
      .empty (q_empty[g]),
      .full  (q_full[g])
    );

    assign q_preg[(2*g)*PREG_W   +: PREG_W] = {TID, head_q[g].src0};
    assign q_preg[(2*g+1)*PREG_W +: PREG_W] = {TID, head_q[g].src1};
    assign head_rdy[g] = !q_empty[g]
                       && (!head_q[g].use0 || q_ready[2*g])
                       && (!head_q[g].use1 || q_ready[2*g+1]);
    assign clr_valid[g] = grant[g] && head_q[g].dst_we;
    assign clr_preg[g*PREG_W +: PREG_W] = {TID, head_q[g].dst};
  end

  assign req = head_rdy & {N{iss_ready && !flush}};

  mtis_scoreboard #(
    .PREG_W(PREG_W), .WB_PORTS(WB_PORTS), .CLR_PORTS(N), .NQ(NQ)
  ) u_sb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wb_valid  (wb_valid),
    .wb_preg   (wb_preg),
    .clr_valid (clr_valid),
    .clr_preg  (clr_preg),
    .q_preg    (q_preg),
    .q_ready   (q_ready)
  );

  mtis_rr_select #(.TID_W(TID_W), .ISSUE_W(ISSUE_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .grant    (grant),
    .slot_vld (slot_vld),
    .slot_tid (slot_tid)
  );

  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) begin
      logic [TID_W-1:0] tk;
      tk = slot_tid[k*TID_W +: TID_W];
      iss_valid[k]                     = slot_vld[k];
      iss_tid[k*TID_W +: TID_W]        = tk;
      iss_dst[k*AREG_W +: AREG_W]      = head_q[tk].dst;
      iss_dst_we[k]                    = slot_vld[k] && head_q[tk].dst_we;
      iss_pay[k*PAY_W +: PAY_W]        = head_q[tk].pay;
    end
  end
endmodule

// File: rtl/mt_inorder_issue_chk.sv
`timescale 1ns/1ps
module mt_inorder_issue_chk
  import mtis_pkg::*;
#(
  parameter int ISSUE_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flush,
  input logic                     iss_ready,
  input logic                     disp_ready,
  input logic [ISSUE_W-1:0]       iss_valid,
  input logic [ISSUE_W*TID_W-1:0] iss_tid
);
  logic [NUM_THREADS-1:0] tid_mask;

  always_comb begin
    tid_mask = '0;
    for (int k = 0; k < ISSUE_W; k++)
      if (iss_valid[k]) tid_mask[iss_tid[k*TID_W +: TID_W]] = 1'b1;
  end

  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> (iss_valid == '0));

  // R10
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!disp_ready && (iss_valid == '0)));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (iss_valid == '0));

  // R4
  one_per_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tid_mask) == $countones(iss_valid));

  for (genvar k = 1; k < ISSUE_W; k++) begin : g_pack
    // R7
    packed_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k] |-> iss_valid[k-1]);
  end
endmodule

bind mt_inorder_issue mt_inorder_issue_chk #(.ISSUE_W(ISSUE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .iss_ready  (iss_ready),
  .disp_ready (disp_ready),
  .iss_valid  (iss_valid),
  .iss_tid    (iss_tid)
);

// File: tb/mt_inorder_issue_tb.sv
`timescale 1ns/1ps
module mt_inorder_issue_tb;
  import mtis_pkg::*;
  localparam int IW = 4;
  localparam int WBP = 2;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [TID_W-1:0] disp_tid = '0;
  logic [AREG_W-1:0] disp_src0 = '0, disp_src1 = '0, disp_dst = '0;
  logic disp_src0_use = 1'b0, disp_src1_use = 1'b0, disp_dst_we = 1'b0;
  logic [PAY_W-1:0] disp_pay = '0;
  logic iss_ready = 1'b0;
  logic [IW-1:0] iss_valid, iss_dst_we;
  logic [IW*TID_W-1:0] iss_tid;
  logic [IW*AREG_W-1:0] iss_dst;
  logic [IW*PAY_W-1:0] iss_pay;
  logic [WBP-1:0] wb_valid = '0;
  logic [WBP*PREG_W-1:0] wb_preg = '0;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  mt_inorder_issue #(.ISSUE_W(IW), .FIFO_DEPTH(2), .WB_PORTS(WBP)) u_dut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_slot(input string req, input int k, input bit v, input int tid, input int pay);
    chk_eq(req, $sformatf("slot%0d valid", k), int'(iss_valid[k]), int'(v));
    if (v) begin
      chk_eq(req, $sformatf("slot%0d tid", k), int'(iss_tid[k*TID_W +: TID_W]), tid);
      chk_eq(req, $sformatf("slot%0d pay", k), int'(iss_pay[k*PAY_W +: PAY_W]), pay);
    end
  endtask

  task automatic push(input int tid, input int s0, input bit u0, input int s1, input bit u1,
                      input int dst, input bit we, input int pay);
    disp_valid = 1'b1; disp_tid = TID_W'(tid);
    disp_src0 = AREG_W'(s0); disp_src0_use = u0;
    disp_src1 = AREG_W'(s1); disp_src1_use = u1;
    disp_dst = AREG_W'(dst); disp_dst_we = we; disp_pay = PAY_W'(pay);
    step();
    disp_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; iss_ready = 1'b0; flush = 1'b0; wb_valid = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk_eq("R1", "iss_valid after reset", int'(iss_valid), 0);
    disp_tid = 3'd5; #0.1;
    chk_eq("R1", "disp_ready after reset", int'(disp_ready), 1);
    step();
  endtask

  task automatic t_basic();
    iss_ready = 1'b1;
    push(3, 7, 1, 0, 0, 1, 1, 'h31);
    @(negedge clk);
    // R1: source never written, issues right away
    chk_slot("R1", 0, 1, 3, 'h31);
    chk_eq("R4", "dst_we slot0", int'(iss_dst_we[0]), 1);
    chk_eq("R4", "dst slot0", int'(iss_dst[0 +: AREG_W]), 1);
    chk_slot("R7", 1, 0, 0, 0);
    step();
    @(negedge clk);
    chk_eq("R4", "popped after issue", int'(iss_valid), 0);
    step();
  endtask

  task automatic t_dep_bypass();
    iss_ready = 1'b1;
    push(1, 2, 1, 0, 0, 2, 1, 'hA1);   // self-dependent writer of r2
    @(negedge clk);
    chk_slot("R5", 0, 1, 1, 'hA1);
    step();
    push(1, 2, 1, 0, 0, 0, 0, 'hB1);   // reader of r2, pending since A issued
    @(negedge clk);
    chk_eq("R6", "dependent waits", int'(iss_valid), 0);
    step();
    wb_valid = 2'b01; wb_preg = {7'd0, 3'd2, 4'd2};
    @(negedge clk);
    chk_eq("R2", "other thread same areg no wake", int'(iss_valid), 0);
    step();
    wb_valid = 2'b10; wb_preg = {3'd1, 4'd2, 7'd0};
    @(negedge clk);
    chk_slot("R5", 0, 1, 1, 'hB1);
    step();
    wb_valid = '0;
    @(negedge clk);
    chk_eq("R4", "reader popped", int'(iss_valid), 0);
    step();
  endtask

  task automatic t_rr();
    do_reset();
    iss_ready = 1'b0;
    for (int t = 0; t < 6; t++) push(t, 0, 0, 0, 0, 0, 0, 'hC0 + t);
    @(negedge clk);
    chk_eq("R9", "no issue while stalled", int'(iss_valid), 0);
    step();
    iss_ready = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) chk_slot("R7", k, 1, k, 'hC0 + k);
    step();
    @(negedge clk);
    chk_slot("R8", 0, 1, 4, 'hC4);
    chk_slot("R8", 1, 1, 5, 'hC5);
    chk_slot("R7", 2, 0, 0, 0);
    step();
    iss_ready = 1'b0;
    push(1, 0, 0, 0, 0, 0, 0, 'hD1);
    push(3, 0, 0, 0, 0, 0, 0, 'hD3);
    push(6, 0, 0, 0, 0, 0, 0, 'hD6);
    push(7, 0, 0, 0, 0, 0, 0, 'hD7);
    iss_ready = 1'b1;
    @(negedge clk);
    // R8: pointer sits at 6 after last granting 5
    chk_slot("R8", 0, 1, 6, 'hD6);
    chk_slot("R8", 1, 1, 7, 'hD7);
    chk_slot("R7", 2, 1, 1, 'hD1);
    chk_slot("R7", 3, 1, 3, 'hD3);
    step();
  endtask

  task automatic t_full_order();
    iss_ready = 1'b0;
    push(4, 0, 0, 0, 0, 0, 0, 'hE1);
    push(4, 0, 0, 0, 0, 0, 0, 'hE2);
    @(negedge clk);
    disp_tid = 3'd4; #0.1;
    chk_eq("R3", "full thread not ready", int'(disp_ready), 0);
    disp_tid = 3'd5; #0.1;
    chk_eq("R3", "other thread ready", int'(disp_ready), 1);
    step();
    iss_ready = 1'b1;
    @(negedge clk);
    chk_slot("R4", 0, 1, 4, 'hE1);
    chk_slot("R4", 1, 0, 0, 0);
    step();
    @(negedge clk);
    chk_slot("R4", 0, 1, 4, 'hE2);
    step();
    @(negedge clk);
    chk_eq("R4", "thread 4 drained", int'(iss_valid), 0);
    step();
  endtask

  task automatic t_flush();
    iss_ready = 1'b1;
    push(6, 0, 0, 0, 0, 5, 1, 'hF0);   // writer of r5, issues
    @(negedge clk);
    chk_slot("R6", 0, 1, 6, 'hF0);
    step();
    push(6, 5, 1, 0, 0, 0, 0, 'hF1);   // reader stalls
    @(negedge clk);
    chk_eq("R6", "reader of pending r5 waits", int'(iss_valid), 0);
    step();
    iss_ready = 1'b0;
    push(4, 0, 0, 0, 0, 0, 0, 'hF4);
    flush = 1'b1; iss_ready = 1'b1; disp_tid = 3'd2;
    @(negedge clk);
    chk_eq("R10", "disp_ready during flush", int'(disp_ready), 0);
    chk_eq("R10", "no issue during flush", int'(iss_valid), 0);
    step();
    flush = 1'b0;
    @(negedge clk);
    chk_eq("R10", "queues empty after flush", int'(iss_valid), 0);
    step();
    push(6, 5, 1, 0, 0, 0, 0, 'hF2);
    @(negedge clk);
    chk_slot("R10", 0, 1, 6, 'hF2);
    step();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_dep_bypass();
    t_rr();
    t_full_order();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #40000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule